// File: doc/BRIEF.md
# Branch-Folding Decoded Instruction Cache

This block sits between a variable-length instruction decoder and a three-stage execute pipeline. It holds instructions that are already decoded into a fixed-width form. Entries are found by fetch address in a direct-mapped array of thirty-two slots, each with a valid bit and an address tag. When the decoder finds a conditional branch right behind an instruction, it hands both over as one fill. The cache then folds the branch into that instruction's entry. At fill time the entry gets two addresses: the one the static prediction bit chooses, stored as the next address, and the other path's address, stored as the alternate. A predicted branch therefore never takes an issue slot of its own.

Lookup runs from an internal fetch register. On a hit, the entry moves into an issue register and the fetch register loads the entry's next address in the same cycle, so a hit stream issues one entry per clock. On a miss the block holds the miss request and address steady until the decoder fills that address. The issue side is a valid/ready stream. The fill side is a valid/ready stream whose ready drops only in an invalidate cycle. A fill offered then is not taken and must be held until ready returns. When execute finds a folded branch mispredicted, it pulses `mispredict` with the alternate address it received with the entry. The block then throws away the entry in its issue register and restarts lookup at that address. There is no delay slot: every entry issued after a branch comes from the predicted path or, after a redirect, the corrected one.

Top module: `fold_dcache`

## Requirements
- R1: During reset and in the first cycle after it, `iss_valid` is 0, `fill_ready` is 1, and lookup starts at START_PC with every entry invalid, so `miss_req` is 1 with `miss_pc` equal to START_PC.
- R2: While the lookup address has no valid entry with a matching tag, `miss_req` is 1 and `miss_pc` equals the lookup address. No new entry is issued until a fill for that address is accepted, which happens on any cycle with `fill_valid` and `fill_ready` both high.
- R3: After a fill is accepted for an address, the lookup of that address issues an entry whose `iss_pc` and `iss_op` equal the filled address and decoded word. Issued entries follow each other along the predicted path: each one's `iss_pc` is the previous one's `iss_next_pc`.
- R4: Length codes on `fill_len` and `fill_br_len` are 00 = 2 bytes, 01 = 6 bytes, 10 = 10 bytes and 11 = 2 bytes. For an unfolded fill (`fill_folded` = 0), `iss_next_pc` = pc + length, `iss_alt_pc` = `iss_next_pc`, and `iss_folded` and `iss_pred` are 0. All address sums wrap modulo 2^AW.
- R5: For a folded fill, the fall-through address is pc + length + branch length. With `fill_pred` = 1, `iss_next_pc` is `fill_target` and `iss_alt_pc` is the fall-through address. With `fill_pred` = 0 the two are swapped. `iss_folded` is 1 and `iss_pred` equals `fill_pred`.
- R6: When lookup hits, `mispredict` is low and the issue register is empty or being accepted, the next cycle presents a valid entry. A loop that includes a folded taken branch therefore issues with no bubble once it is cached.
- R7: While `iss_valid` is 1 and `iss_ready` is 0 (and no mispredict), the presented entry and `iss_valid` stay unchanged, and lookup does not advance.
- R8: A `mispredict` pulse clears `iss_valid` in the next cycle, whatever `iss_ready` is, and restarts lookup at `redirect_pc`. The first entry issued after it has `iss_pc` equal to `redirect_pc`.
- R9: `inval_all` clears every valid bit in one cycle. `fill_ready` is 0 in that cycle, and the following cycle's lookup misses.
- R10: The array is direct-mapped: index = pc bits [5:1] and tag = pc bits [AW-1:6] for 32 entries. A fill to an address with the same index but a different tag replaces the old entry, and a later lookup of the old address misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Decoder offers a decoded entry |
| fill_ready | output | 1 | Fill accepted this cycle if valid; low only while invalidating |
| fill_pc | input | AW | Fetch address of the decoded instruction |
| fill_op | input | OPW | Fixed-width decoded instruction word |
| fill_len | input | 2 | Instruction length code |
| fill_folded | input | 1 | A conditional branch follows and is folded in |
| fill_br_len | input | 2 | Length code of the folded branch |
| fill_pred | input | 1 | Static prediction of the folded branch, 1 = taken |
| fill_target | input | AW | Taken target of the folded branch |
| miss_req | output | 1 | Lookup address is not cached |
| miss_pc | output | AW | Address the decoder must fill |
| iss_valid | output | 1 | Issue register holds an entry |
| iss_ready | input | 1 | Execute accepts the presented entry |
| iss_pc | output | AW | Address of the issued entry |
| iss_op | output | OPW | Decoded word of the issued entry |
| iss_folded | output | 1 | Entry carries a folded branch |
| iss_pred | output | 1 | Prediction of the folded branch |
| iss_next_pc | output | AW | Predicted-path next address |
| iss_alt_pc | output | AW | Other-path address, used as redirect on mispredict |
| mispredict | input | 1 | Execute found a folded branch mispredicted |
| redirect_pc | input | AW | Restart address on mispredict |
| inval_all | input | 1 | Clear all valid bits |

## Verification
A wrong tag or index shows up at the ports as an issued entry with an `iss_pc` that breaks the predicted-path chain. It can also show up as a missing or extra `miss_req`, one cycle after the lookup address is loaded. A bad next-address sum or a swapped path shows on the same issue as a wrong `iss_next_pc` or `iss_alt_pc`, and the entry after it then comes from the wrong address. A stale valid bit after invalidate, or an issue register that survives a squash, is visible in the cycle right after `inval_all` or `mispredict`.

// File: rtl/fdc_pkg.sv
`timescale 1ns/1ps
package fdc_pkg;

  typedef enum logic [1:0] {
    ILEN_2  = 2'b00,
    ILEN_6  = 2'b01,
    ILEN_10 = 2'b10,
    ILEN_RS = 2'b11
  } ilen_e;

  // byte count of an instruction length code; the reserved code counts as 2
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    logic [3:0] b;
    case (ilen_e'(code))
      ILEN_6:  b = 4'd6;
      ILEN_10: b = 4'd10;
      default: b = 4'd2;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/fdc_nextpc.sv
`timescale 1ns/1ps
// Forms the predicted and alternate addresses of an entry at fill time.
module fdc_nextpc #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic [1:0]    len,
  input  logic          folded,
  input  logic [1:0]    br_len,
  input  logic          pred,
  input  logic [AW-1:0] target,
  output logic          pred_eff,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] alt_pc
);
  import fdc_pkg::*;

  localparam int PADW = AW - 4;

  logic [3:0]    own_bytes;
  logic [3:0]    br_bytes;
  logic [AW-1:0] fall_pc;

  always_comb begin
    own_bytes = len_bytes(len);
    br_bytes  = folded ? len_bytes(br_len) : 4'd0;
    fall_pc   = pc + {{PADW{1'b0}}, own_bytes} + {{PADW{1'b0}}, br_bytes};
    pred_eff  = folded & pred;
    if (!folded) begin
      next_pc = fall_pc;
      alt_pc  = fall_pc;
    end else if (pred) begin
      next_pc = target;
      alt_pc  = fall_pc;
    end else begin
      next_pc = fall_pc;
      alt_pc  = target;
    end
  end

endmodule

// File: rtl/fdc_store.sv
`timescale 1ns/1ps
// Direct-mapped entry array: valid and tag per slot, one write and one read port.
module fdc_store #(
  parameter int AW      = 16,
  parameter int OPW     = 32,
  parameter int ENTRIES = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inval,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_pc,
  input  logic [OPW-1:0] wr_op,
  input  logic           wr_folded,
  input  logic           wr_pred,
  input  logic [AW-1:0]  wr_next,
  input  logic [AW-1:0]  wr_alt,
  input  logic [AW-1:0]  rd_pc,
  output logic           rd_hit,
  output logic [OPW-1:0] rd_op,
  output logic           rd_folded,
  output logic           rd_pred,
  output logic [AW-1:0]  rd_next,
  output logic [AW-1:0]  rd_alt
);
  localparam int IDXW = $clog2(ENTRIES);
  localparam int TAGW = AW - IDXW - 1;

  logic [ENTRIES-1:0] valid_q;
  logic [TAGW-1:0]    tag_q    [ENTRIES];
  logic [OPW-1:0]     op_q     [ENTRIES];
  logic               folded_q [ENTRIES];
  logic               pred_q   [ENTRIES];
  logic [AW-1:0]      next_q   [ENTRIES];
  logic [AW-1:0]      alt_q    [ENTRIES];

  logic [IDXW-1:0] w_idx, r_idx;
  logic [TAGW-1:0] w_tag, r_tag;
  logic            unused_lsb;

  assign w_idx      = wr_pc[IDXW:1];
  assign w_tag      = wr_pc[AW-1:IDXW+1];
  assign r_idx      = rd_pc[IDXW:1];
  assign r_tag      = rd_pc[AW-1:IDXW+1];
  assign unused_lsb = wr_pc[0] ^ rd_pc[0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rst_n)                                 valid_q[g] <= 1'b0;
      else if (inval)                             valid_q[g] <= 1'b0;
      else if (wr_en && w_idx == IDXW'(g))        valid_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inval) begin
      tag_q[w_idx]    <= w_tag;
      op_q[w_idx]     <= wr_op;
      folded_q[w_idx] <= wr_folded;
      pred_q[w_idx]   <= wr_pred;
      next_q[w_idx]   <= wr_next;
      alt_q[w_idx]    <= wr_alt;
    end
  end

  always_comb begin
    rd_hit    = valid_q[r_idx] && (tag_q[r_idx] == r_tag);
    rd_op     = op_q[r_idx];
    rd_folded = folded_q[r_idx];
    rd_pred   = pred_q[r_idx];
    rd_next   = next_q[r_idx];
    rd_alt    = alt_q[r_idx];
  end

endmodule

// File: rtl/fdc_issue.sv
`timescale 1ns/1ps
// Fetch address register and issue register with squash on mispredict.
module fdc_issue #(
  parameter int            AW       = 16,
  parameter int            OPW      = 32,
  parameter logic [AW-1:0] START_PC = AW'('h0100)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic [OPW-1:0] hit_op,
  input  logic           hit_folded,
  input  logic           hit_pred,
  input  logic [AW-1:0]  hit_next,
  input  logic [AW-1:0]  hit_alt,
  input  logic           mispredict,
  input  logic [AW-1:0]  redirect_pc,
  input  logic           iss_ready,
  output logic [AW-1:0]  lookup_pc,
  output logic           iss_valid,
  output logic [AW-1:0]  iss_pc,
  output logic [OPW-1:0] iss_op,
  output logic           iss_folded,
  output logic           iss_pred,
  output logic [AW-1:0]  iss_next_pc,
  output logic [AW-1:0]  iss_alt_pc
);
  logic [AW-1:0] fetch_q;
  logic          out_v_q;
  logic          slot_free;
  logic          take;

  assign slot_free = !out_v_q || iss_ready;
  assign take      = hit && slot_free && !mispredict;
  assign lookup_pc = fetch_q;
  assign iss_valid = out_v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q <= START_PC;
      out_v_q <= 1'b0;
    end else if (mispredict) begin
      fetch_q <= redirect_pc;
      out_v_q <= 1'b0;
    end else if (take) begin
      fetch_q <= hit_next;
      out_v_q <= 1'b1;
    end else if (iss_ready) begin
      out_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      iss_pc      <= fetch_q;
      iss_op      <= hit_op;
      iss_folded  <= hit_folded;
      iss_pred    <= hit_pred;
      iss_next_pc <= hit_next;
      iss_alt_pc  <= hit_alt;
    end
  end

endmodule

// File: rtl/fold_dcache.sv
`timescale 1ns/1ps
module fold_dcache #(
  parameter int            AW       = 16,
  parameter int            OPW      = 32,
  parameter int            ENTRIES  = 32,
  parameter logic [AW-1:0] START_PC = AW'('h0100)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fill_valid,
  output logic           fill_ready,
  input  logic [AW-1:0]  fill_pc,
  input  logic [OPW-1:0] fill_op,
  input  logic [1:0]     fill_len,
  input  logic           fill_folded,
  input  logic [1:0]     fill_br_len,
  input  logic           fill_pred,
  input  logic [AW-1:0]  fill_target,
  output logic           miss_req,
  output logic [AW-1:0]  miss_pc,
  output logic           iss_valid,
  input  logic           iss_ready,
  output logic [AW-1:0]  iss_pc,
  output logic [OPW-1:0] iss_op,
  output logic           iss_folded,
  output logic           iss_pred,
  output logic [AW-1:0]  iss_next_pc,
  output logic [AW-1:0]  iss_alt_pc,
  input  logic           mispredict,
  input  logic [AW-1:0]  redirect_pc,
  input  logic           inval_all
);
  logic           fill_we;
  logic           w_pred;
  logic [AW-1:0]  w_next, w_alt;
  logic [AW-1:0]  lookup_pc;
  logic           r_hit, r_folded, r_pred;
  logic [OPW-1:0] r_op;
  logic [AW-1:0]  r_next, r_alt;

  assign fill_ready = !inval_all;
  assign fill_we    = fill_valid && fill_ready;
  assign miss_req   = !r_hit;
  assign miss_pc    = lookup_pc;

  fdc_nextpc #(.AW(AW)) u_nextpc (
    .pc       (fill_pc),
    .len      (fill_len),
    .folded   (fill_folded),
    .br_len   (fill_br_len),
    .pred     (fill_pred),
    .target   (fill_target),
    .pred_eff (w_pred),
    .next_pc  (w_next),
    .alt_pc   (w_alt)
  );

  fdc_store #(.AW(AW), .OPW(OPW), .ENTRIES(ENTRIES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .inval     (inval_all),
    .wr_en     (fill_we),
    .wr_pc     (fill_pc),
    .wr_op     (fill_op),
    .wr_folded (fill_folded),
    .wr_pred   (w_pred),
    .wr_next   (w_next),
    .wr_alt    (w_alt),
    .rd_pc     (lookup_pc),
    .rd_hit    (r_hit),
    .rd_op     (r_op),
    .rd_folded (r_folded),
    .rd_pred   (r_pred),
    .rd_next   (r_next),
    .rd_alt    (r_alt)
  );

  fdc_issue #(.AW(AW), .OPW(OPW), .START_PC(START_PC)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (r_hit),
    .hit_op      (r_op),
    .hit_folded  (r_folded),
    .hit_pred    (r_pred),
    .hit_next    (r_next),
    .hit_alt     (r_alt),
    .mispredict  (mispredict),
    .redirect_pc (redirect_pc),
    .iss_ready   (iss_ready),
    .lookup_pc   (lookup_pc),
    .iss_valid   (iss_valid),
    .iss_pc      (iss_pc),
    .iss_op      (iss_op),
    .iss_folded  (iss_folded),
    .iss_pred    (iss_pred),
    .iss_next_pc (iss_next_pc),
    .iss_alt_pc  (iss_alt_pc)
  );

endmodule

// File: rtl/fold_dcache_chk.sv
`timescale 1ns/1ps
module fold_dcache_chk #(
  parameter int AW  = 16,
  parameter int OPW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mispredict,
  input logic           inval_all,
  input logic           fill_ready,
  input logic           miss_req,
  input logic           iss_valid,
  input logic           iss_ready,
  input logic [AW-1:0]  iss_pc,
  input logic [OPW-1:0] iss_op,
  input logic           iss_folded,
  input logic           iss_pred,
  input logic [AW-1:0]  iss_next_pc,
  input logic [AW-1:0]  iss_alt_pc
);

  p_no_issue_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req && !iss_valid |=> !iss_valid);

  p_unfolded_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_folded |-> (iss_alt_pc == iss_next_pc) && !iss_pred);

  p_no_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_req && !mispredict && (iss_ready || !iss_valid) |=> iss_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready && !mispredict |=>
      iss_valid && $stable(iss_pc) && $stable(iss_op) && $stable(iss_next_pc)
      && $stable(iss_alt_pc) && $stable(iss_folded) && $stable(iss_pred));

  p_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> !iss_valid);

  p_fill_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |-> !fill_ready);

  p_miss_after_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> miss_req);

endmodule

bind fold_dcache fold_dcache_chk #(.AW(AW), .OPW(OPW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mispredict  (mispredict),
  .inval_all   (inval_all),
  .fill_ready  (fill_ready),
  .miss_req    (miss_req),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .iss_pc      (iss_pc),
  .iss_op      (iss_op),
  .iss_folded  (iss_folded),
  .iss_pred    (iss_pred),
  .iss_next_pc (iss_next_pc),
  .iss_alt_pc  (iss_alt_pc)
);

// File: tb/fold_dcache_tb.sv
`timescale 1ns/1ps
module fold_dcache_tb;
  localparam int            AW    = 16;
  localparam int            OPW   = 32;
  localparam logic [15:0]   START = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           fill_valid = 0, fill_folded = 0, fill_pred = 0;
  logic           fill_ready;
  logic [AW-1:0]  fill_pc = '0, fill_target = '0;
  logic [OPW-1:0] fill_op = '0;
  logic [1:0]     fill_len = '0, fill_br_len = '0;
  logic           miss_req, iss_valid, iss_folded, iss_pred;
  logic [AW-1:0]  miss_pc, iss_pc, iss_next_pc, iss_alt_pc;
  logic [OPW-1:0] iss_op;
  logic           iss_ready = 0, mispredict = 0, inval_all = 0;
  logic [AW-1:0]  redirect_pc = '0;

  fold_dcache #(.AW(AW), .OPW(OPW), .ENTRIES(32), .START_PC(START)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_pc(fill_pc),
    .fill_op(fill_op), .fill_len(fill_len), .fill_folded(fill_folded),
    .fill_br_len(fill_br_len), .fill_pred(fill_pred), .fill_target(fill_target),
    .miss_req(miss_req), .miss_pc(miss_pc),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_pc(iss_pc), .iss_op(iss_op),
    .iss_folded(iss_folded), .iss_pred(iss_pred), .iss_next_pc(iss_next_pc),
    .iss_alt_pc(iss_alt_pc), .mispredict(mispredict), .redirect_pc(redirect_pc),
    .inval_all(inval_all)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [AW-1:0] exp_pc;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [1:0]     len;
    logic           folded;
    logic [1:0]     brlen;
    logic           pred;
    logic [AW-1:0]  tgt;
  } pent_t;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nbytes(input logic [1:0] c);
    return (c == 2'd1) ? 16'd6 : (c == 2'd2) ? 16'd10 : 16'd2;
  endfunction

  // bench program image: a 3-entry loop at 0x100 and a hashed pattern elsewhere
  function automatic pent_t prog(input logic [AW-1:0] pc);
    pent_t e;
    logic [14:0] ix;
    ix       = pc[15:1];
    e.op     = {~pc, pc};
    e.len    = 2'(ix % 15'd3);
    e.folded = ix[2];
    e.pred   = ix[3];
    e.brlen  = 2'((ix >> 4) % 15'd3);
    e.tgt    = (pc * 16'd13 + 16'h002A) & 16'hFFFE;
    if (pc == 16'h0100) begin e.len = 2'd0; e.folded = 1'b0; end
    if (pc == 16'h0102) begin e.len = 2'd1; e.folded = 1'b0; end
    if (pc == 16'h0108) begin
      e.len = 2'd2; e.folded = 1'b1; e.pred = 1'b1; e.brlen = 2'd0; e.tgt = 16'h0100;
    end
    return e;
  endfunction

  task automatic check_xfer();
    pent_t e;
    logic [AW-1:0] fall, en, ea;
    e = prog(iss_pc);
    chk(iss_pc == exp_pc, "R3 path pc", iss_pc, exp_pc);
    chk(iss_op == e.op, "R3 op", iss_op, e.op);
    fall = iss_pc + nbytes(e.len) + (e.folded ? nbytes(e.brlen) : 16'd0);
    if (!e.folded) begin en = fall; ea = fall; end
    else if (e.pred) begin en = e.tgt; ea = fall; end
    else begin en = fall; ea = e.tgt; end
    if (e.folded) begin
      chk(iss_next_pc == en, "R5 next", iss_next_pc, en);
      chk(iss_alt_pc == ea, "R5 alt", iss_alt_pc, ea);
      chk(iss_folded && iss_pred == e.pred, "R5 flags", {iss_folded, iss_pred}, {1'b1, e.pred});
    end else begin
      chk(iss_next_pc == en, "R4 next", iss_next_pc, en);
      chk(iss_alt_pc == ea, "R4 alt", iss_alt_pc, ea);
      chk(!iss_folded && !iss_pred, "R4 flags", {iss_folded, iss_pred}, 2'b00);
    end
    exp_pc = en;
  endtask

  // one clock: called at a negedge, drives inputs, acts as decoder, returns at next negedge
  task automatic cyc(input bit rdy, input bit mp, input logic [AW-1:0] rpc, input bit inv);
    pent_t e;
    iss_ready   = rdy;
    mispredict  = mp;
    redirect_pc = rpc;
    inval_all   = inv;
    if (miss_req) begin
      e = prog(miss_pc);
      fill_valid  = 1'b1;
      fill_pc     = miss_pc;
      fill_op     = e.op;
      fill_len    = e.len;
      fill_folded = e.folded;
      fill_br_len = e.brlen;
      fill_pred   = e.pred;
      fill_target = e.tgt;
    end else begin
      fill_valid = 1'b0;
    end
    #1;
    chk(fill_ready == !inv, "R9 fill_ready", fill_ready, !inv);
    if (iss_valid && rdy && !mp) check_xfer();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(!iss_valid, "R1 iss_valid", iss_valid, 0);
    chk(miss_req && miss_pc == START, "R1 R2 first miss", {miss_req, miss_pc}, {1'b1, START});
    chk(fill_ready, "R1 fill_ready", fill_ready, 1);
    @(negedge clk);
    exp_pc = START;

    // R2 R3: warm the loop
    repeat (20) cyc(1, 0, '0, 0);
    // R6: cached loop with folded taken branch issues every cycle
    for (int i = 0; i < 12; i++) begin
      chk(iss_valid, "R6 no bubble", iss_valid, 1);
      cyc(1, 0, '0, 0);
    end

    // R7: back-pressure holds the entry
    held = iss_pc;
    chk(iss_valid, "R7 valid before stall", iss_valid, 1);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, '0, 0);
      chk(iss_valid && iss_pc == held, "R7 hold", iss_pc, held);
    end
    repeat (6) cyc(1, 0, '0, 0);

    // R8: squash and restart at the redirect address
    exp_pc = 16'h0102;
    cyc(0, 1, 16'h0102, 0);
    chk(!iss_valid, "R8 squash", iss_valid, 0);
    cyc(1, 0, '0, 0);
    chk(iss_valid && iss_pc == 16'h0102, "R8 restart", iss_pc, 16'h0102);
    repeat (6) cyc(1, 0, '0, 0);

    // R10: same index, different tag evicts
    exp_pc = 16'h0140;
    cyc(0, 1, 16'h0140, 0);
    for (int i = 0; i < 10; i++) if (!iss_valid) cyc(0, 0, '0, 0);
    chk(iss_valid && iss_pc == 16'h0140, "R10 conflict fill", iss_pc, 16'h0140);
    exp_pc = 16'h0100;
    cyc(0, 1, 16'h0100, 0);
    chk(miss_req && miss_pc == 16'h0100, "R10 evicted", {miss_req, miss_pc}, {1'b1, 16'h0100});
    repeat (10) cyc(1, 0, '0, 0);

    // R9: invalidate all
    cyc(1, 0, '0, 1);
    chk(miss_req, "R9 miss after invalidate", miss_req, 1);
    repeat (10) cyc(1, 0, '0, 0);

    // R4 R5: sweep many start points through the hashed program
    for (int s = 0; s < 80; s++) begin
      logic [AW-1:0] r;
      r = AW'((s * 38 + 16'h0400) & 16'hFFFE);
      exp_pc = r;
      cyc(0, 1, r, 0);
      repeat (12) cyc(s[0], 0, '0, 0);
      repeat (6) cyc(1, 0, '0, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule